// File: doc/BRIEF.md
# Conditional Integer ALU with Status Flags

This block is the integer execute stage of a small processor core. Every cycle it takes two operands, an operation code and a 4-bit condition code. It decides from its own stored status flags whether the operation executes. When it does, the block presents the result with a write enable for the destination register. When flag setting is requested, it also loads new negative, zero, carry and overflow flags into its status register on the next clock edge.

The result and the write enable are combinational and follow the inputs in the same cycle. The status flags are registered. The carry input of the add-with-carry and subtract-with-carry forms comes from the stored carry flag. Logical operations take their carry from a shifter outside the block. The four test forms compute a value only to set flags, and they never ask for a register write. The datapath width is a parameter.

Top module: `alu_nzcv_unit`

## Requirements
- R1: Opcode encodings for arithmetic: 4=add a+b, 5=add with carry a+b+C, 2=subtract a-b, 6=subtract with carry a-b-(1-C), 3=reverse subtract b-a, 7=reverse subtract with carry b-a-(1-C). All results are taken modulo 2^W, and C is the stored carry flag.
- R2: Opcode encodings for logic: 0=a AND b, 1=a XOR b, 12=a OR b, 13=b, 14=a AND NOT b, 15=NOT b.
- R3: Arithmetic flag values on `flags` = {N,Z,C,V} (bit 3 down to bit 0). N is the result MSB and Z means the result is zero. C is the carry out of an addition, or "no borrow" for a subtraction. V is signed overflow. For example, all-ones plus one gives 0110, and the most positive value plus one gives 1001.
- R4: Logical operations set N and Z from the value, take C from `shift_carry`, and keep V.
- R5: Opcodes 8 (AND), 9 (XOR), 10 (subtract a-b) and 11 (add a+b) are test forms. They never raise `wr_en`, but they update flags like their counterparts.
- R6: Condition codes 0..7 pass when, in order: Z=1, Z=0, C=1, C=0, N=1, N=0, V=1, V=0.
- R7: Condition codes 8..13 pass when, in order: C=1 and Z=0; C=0 or Z=1; N=V; N!=V; Z=0 and N=V; Z=1 or N!=V.
- R8: Condition codes 14 and 15 always pass.
- R9: When the condition fails, `wr_en` is 0 and the flags do not change.
- R10: The flags load on a rising clock edge only when `set_flags` is 1 and the condition passes. Otherwise they hold.
- R11: A synchronous active-high reset clears the flags to 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | W | First operand |
| op_b | input | W | Second operand (already shifted) |
| opcode | input | 4 | Operation select |
| set_flags | input | 1 | Request to update the flags |
| shift_carry | input | 1 | Carry out of the external shifter |
| cond | input | 4 | Condition code tested against stored flags |
| result | output | W | Operation result (combinational) |
| wr_en | output | 1 | Destination write enable (combinational) |
| flags | output | 4 | Stored {N,Z,C,V} |

## Verification
The assertions check on every cycle that a failed condition blocks the write and freezes the flags, and that the flags hold whenever no update is requested. They also check that test forms never write, that logical updates keep V, and that the always codes write for every non-test operation. The numeric results, the carry and overflow values of each arithmetic form, and the pass table of every condition over the flag states reached are shown only by the bench. The bench sweeps operand corner values across all opcodes and condition codes against an arithmetic model.

// File: rtl/alu_nzcv_pkg.sv
package alu_nzcv_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
        OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
        OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
        OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
    } alu_op_e;

    typedef enum logic [3:0] {
        CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
        CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
        CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
        CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_AX = 4'd15
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    // Test forms: codes 8..11
    function automatic logic is_test_op(alu_op_e op);
        return op[3:2] == 2'b10;
    endfunction

    function automatic logic is_logic_op(alu_op_e op);
        case (op)
            OP_AND, OP_EOR, OP_TST, OP_TEQ,
            OP_ORR, OP_MOV, OP_BIC, OP_MVN: return 1'b1;
            default:                        return 1'b0;
        endcase
    endfunction

    function automatic logic cond_met(cond_e cc, nzcv_t f);
        case (cc)
            CC_EQ:   return f.z;
            CC_NE:   return !f.z;
            CC_CS:   return f.c;
            CC_CC:   return !f.c;
            CC_MI:   return f.n;
            CC_PL:   return !f.n;
            CC_VS:   return f.v;
            CC_VC:   return !f.v;
            CC_HI:   return f.c && !f.z;
            CC_LS:   return !f.c || f.z;
            CC_GE:   return f.n == f.v;
            CC_LT:   return f.n != f.v;
            CC_GT:   return !f.z && (f.n == f.v);
            CC_LE:   return f.z || (f.n != f.v);
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/alu_nzcv_adder.sv
module alu_nzcv_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    localparam int MSB = W - 1;

    logic [W:0] wide;

    always_comb begin
        wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
        sum  = wide[MSB:0];
        cout = wide[W];
        ovf  = (x[MSB] == y[MSB]) && (wide[MSB] != x[MSB]);
    end
endmodule

// File: rtl/alu_nzcv_datapath.sv
module alu_nzcv_datapath
    import alu_nzcv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    input  nzcv_t        cur,
    input  logic         shift_carry,
    output logic [W-1:0] res,
    output nzcv_t        nxt
);
    localparam int MSB = W - 1;

    logic [W-1:0] add_x, add_y, add_sum, logic_val;
    logic         add_cin, add_cout, add_ovf, is_logic;

    // Operand steering: subtraction is x + ~y + carry-in
    always_comb begin
        add_x   = a;
        add_y   = b;
        add_cin = 1'b0;
        case (op)
            OP_ADC:         add_cin = cur.c;
            OP_SUB, OP_CMP: begin add_y = ~b; add_cin = 1'b1;  end
            OP_SBC:         begin add_y = ~b; add_cin = cur.c; end
            OP_RSB:         begin add_x = b; add_y = ~a; add_cin = 1'b1;  end
            OP_RSC:         begin add_x = b; add_y = ~a; add_cin = cur.c; end
            default:        ;
        endcase
    end

    alu_nzcv_adder #(.W(W)) u_adder (
        .x(add_x), .y(add_y), .cin(add_cin),
        .sum(add_sum), .cout(add_cout), .ovf(add_ovf)
    );

    always_comb begin
        case (op)
            OP_EOR, OP_TEQ: logic_val = a ^ b;
            OP_ORR:         logic_val = a | b;
            OP_MOV:         logic_val = b;
            OP_BIC:         logic_val = a & ~b;
            OP_MVN:         logic_val = ~b;
            default:        logic_val = a & b;
        endcase
    end

    always_comb begin
        is_logic = is_logic_op(op);
        res      = is_logic ? logic_val : add_sum;
        nxt.n    = res[MSB];
        nxt.z    = (res == '0);
        nxt.c    = is_logic ? shift_carry : add_cout;
        nxt.v    = is_logic ? cur.v : add_ovf;
    end
endmodule

// File: rtl/alu_nzcv_cond.sv
module alu_nzcv_cond
    import alu_nzcv_pkg::*;
(
    input  cond_e cc,
    input  nzcv_t f,
    output logic  ok
);
    always_comb ok = cond_met(cc, f);
endmodule

// File: rtl/alu_nzcv_flagreg.sv
module alu_nzcv_flagreg
    import alu_nzcv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  nzcv_t d,
    output nzcv_t q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/alu_nzcv_unit.sv
module alu_nzcv_unit
    import alu_nzcv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [3:0]   opcode,
    input  logic         set_flags,
    input  logic         shift_carry,
    input  logic [3:0]   cond,
    output logic [W-1:0] result,
    output logic         wr_en,
    output logic [3:0]   flags
);
    alu_op_e op;
    cond_e   cc;
    nzcv_t   cur, nxt;
    logic    cond_ok, load;

    assign op = alu_op_e'(opcode);
    assign cc = cond_e'(cond);

    alu_nzcv_cond u_cond (.cc(cc), .f(cur), .ok(cond_ok));

    alu_nzcv_datapath #(.W(W)) u_dp (
        .a(op_a), .b(op_b), .op(op), .cur(cur),
        .shift_carry(shift_carry), .res(result), .nxt(nxt)
    );

    assign load  = set_flags && cond_ok;
    assign wr_en = cond_ok && !is_test_op(op);

    alu_nzcv_flagreg u_flags (
        .clk(clk), .rst(rst), .load(load), .d(nxt), .q(cur)
    );

    assign flags = cur;

    assert_fail_no_write_R9: assert property (@(posedge clk) disable iff (rst)
        !cond_ok |-> !wr_en);
    assert_fail_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !cond_ok |=> $stable(flags));
    assert_no_request_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !set_flags |=> $stable(flags));
    assert_test_no_write_R5: assert property (@(posedge clk) disable iff (rst)
        (opcode[3:2] == 2'b10) |-> !wr_en);
    assert_logic_keeps_v_R4: assert property (@(posedge clk) disable iff (rst)
        (set_flags && cond_ok && is_logic_op(op)) |=> (flags[0] == $past(flags[0])));
    assert_always_writes_R8: assert property (@(posedge clk) disable iff (rst)
        ((cond == 4'd14 || cond == 4'd15) && opcode[3:2] != 2'b10) |-> wr_en);
endmodule

// File: tb/alu_nzcv_unit_test.sv
`timescale 1ns/1ps
module alu_nzcv_unit_test;
    localparam int W = 8;
    localparam int M = 256;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic [3:0]   opcode = '0, cond = 4'd14;
    logic         set_flags = 1'b0, shift_carry = 1'b0;
    logic [W-1:0] result;
    logic         wr_en;
    logic [3:0]   flags;

    int  n_cmp = 0, n_bad = 0;
    bit  done = 1'b0;
    bit  mn = 0, mz = 0, mc = 0, mv = 0;

    always #2.5 clk = ~clk;

    alu_nzcv_unit #(.W(W)) uut (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .opcode(opcode),
        .set_flags(set_flags), .shift_carry(shift_carry), .cond(cond),
        .result(result), .wr_en(wr_en), .flags(flags)
    );

    function automatic bit cond_model(int cc);
        case (cc)
            0: return mz;           1: return !mz;
            2: return mc;           3: return !mc;
            4: return mn;           5: return !mn;
            6: return mv;           7: return !mv;
            8: return mc && !mz;    9: return !mc || mz;
            10: return mn == mv;    11: return mn != mv;
            12: return !mz && mn == mv;
            13: return mz || mn != mv;
            default: return 1'b1;
        endcase
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(int a, int b, int op, bit sf, bit shc, int cc);
        int  r, s, sa, sb, ss;
        bit  en, c, v, pass, test, logic_op;
        string rq;
        @(negedge clk);
        op_a = a[W-1:0]; op_b = b[W-1:0]; opcode = op[3:0];
        set_flags = sf; shift_carry = shc; cond = cc[3:0];
        sa = (a >= M/2) ? a - M : a;
        sb = (b >= M/2) ? b - M : b;
        c = 0; v = mv; r = 0;
        logic_op = (op <= 1) || (op == 8) || (op == 9) || (op >= 12);
        test = (op >= 8) && (op <= 11);
        case (op)
            4, 5, 11: begin
                s  = a + b + ((op == 5) ? int'(mc) : 0);
                ss = sa + sb + ((op == 5) ? int'(mc) : 0);
                r = s % M; c = (s >= M); v = (ss >= M/2) || (ss < -M/2);
            end
            2, 6, 10, 3, 7: begin
                if (op == 3 || op == 7) begin
                    s = b - a; ss = sb - sa;
                end else begin
                    s = a - b; ss = sa - sb;
                end
                if (op == 6 || op == 7) begin
                    s -= (1 - int'(mc)); ss -= (1 - int'(mc));
                end
                c = (s >= 0); r = (s + 2*M) % M;
                v = (ss >= M/2) || (ss < -M/2);
            end
            0, 8:  begin r = a & b;          c = shc; end
            1, 9:  begin r = a ^ b;          c = shc; end
            12:    begin r = a | b;          c = shc; end
            13:    begin r = b;              c = shc; end
            14:    begin r = a & (~b & (M-1)); c = shc; end
            default: begin r = (~b) & (M-1); c = shc; end
        endcase
        pass = cond_model(cc);
        en   = pass && !test;
        #1;
        if (!test) check(logic_op ? "R2" : "R1", "result", int'(result), r);
        rq = !pass ? "R9" : test ? "R5" : (cc < 8) ? "R6" : (cc < 14) ? "R7" : "R8";
        check(rq, "wr_en", int'(wr_en), int'(en));
        rq = !pass ? "R9" : !sf ? "R10" : logic_op ? "R4" : "R3";
        if (sf && pass) begin
            mn = (r >= M/2); mz = (r == 0); mc = c; mv = v;
        end
        @(posedge clk); #1;
        check(rq, "flags", int'(flags), {28'd0, mn, mz, mc, mv});
    endtask

    int vals [16] = '{8'h00, 8'h01, 8'h02, 8'h7F, 8'h80, 8'h81, 8'hFE, 8'hFF,
                      8'h55, 8'hAA, 8'h0F, 8'hF0, 8'h40, 8'hC0, 8'h3C, 8'h10};

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R11", "flags after reset", int'(flags), 0);
        @(negedge clk) rst = 1'b0;

        // R3: all-ones plus one, then most positive plus one
        step(8'hFF, 8'h01, 4, 1, 0, 14);
        check("R3", "neg1 plus 1 flags", int'(flags), 4'b0110);
        step(8'h7F, 8'h01, 4, 1, 0, 14);
        check("R3", "max plus 1 flags", int'(flags), 4'b1001);
        // R1: subtract with carry clear borrows one extra
        step(8'h00, 8'h00, 5, 1, 0, 14);      // flags 0100, C=0
        step(8'h10, 8'h03, 6, 0, 0, 14);
        check("R1", "sbc with C=0", int'(result), 8'h0C);
        // R5: compare sets flags without write
        step(8'h05, 8'h05, 10, 1, 0, 15);
        check("R5", "cmp equal flags", int'(flags), 4'b0110);

        for (int op = 0; op < 16; op++)
            for (int i = 0; i < 16; i++)
                for (int j = 0; j < 16; j++)
                    step(vals[i], vals[j], op, ((i + j) % 5) != 0,
                         ((i ^ j) & 1) == 1, (i * 3 + j + op) % 16);

        // R11: synchronous reset mid-run
        step(8'h80, 8'h00, 13, 1, 1, 14);
        @(negedge clk) rst = 1'b1;
        @(posedge clk); #1;
        check("R11", "flags after mid-run reset", int'(flags), 0);
        mn = 0; mz = 0; mc = 0; mv = 0;
        @(negedge clk) rst = 1'b0;
        step(8'h01, 8'h02, 2, 1, 0, 14);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule